// File: doc/BRIEF.md
# Receive frame buffer writer

This block sits between the receive side of an Ethernet MAC and a byte-wide packet memory. It takes received frames one byte per cycle and stores them in a circular receive region of the memory. Each frame that is kept gets a four-byte header in front of its data. The header holds a marker byte, a status byte and the stored length.

A set of receive-control bits selects which frames are kept. Address, runt, oversize and CRC checks are all decided once the last byte has arrived. A frame that is rejected leaves the committed write pointer where it was, so the bytes already written past it stay invisible to the host. A frame that is kept gets its header written after its data, with the marker byte last. Only then does the write pointer move and the receive-complete interrupt bit get set. The host reads the ring itself and reports its read position back on `rd_ptr`. The writer uses that position to refuse frames that would overrun unread data.

Top module: `rxfw_writer`

## Requirements
- R1: After reset, `wr_ptr` is 0, `irq_stat` is 0 and `mem_we` is low.
- R2: A kept frame of L bytes is stored at committed pointer P as follows. P+0 holds the marker 0x01. P+1 holds the status byte. P+2 and P+3 hold L little-endian, low byte first. The L received bytes, including the 4-byte FCS, go from P+4 onward. Every address wraps modulo RING_BYTES.
- R3: The four header bytes are written after the last data byte, and the marker at P+0 is the last write of the frame.
- R4: When a frame is committed, `wr_ptr` becomes (P+L+4) mod RING_BYTES and `irq_stat[0]` is set. Both change in the same cycle that the marker write appears on the memory port. The input must stay idle for at least 5 cycles after a frame's last byte.
- R5: A rejected frame leaves `wr_ptr` and `irq_stat[0]` unchanged and produces no header write.
- R6: `rx_ctrl[0]` (enable) is sampled on a frame's first byte. If it is 0, the whole frame causes no memory write and no change to `wr_ptr` or `irq_stat`.
- R7: The destination is received bytes 0..5, and byte 0 is compared with `own_addr[7:0]`. A frame is group (multicast or broadcast) when bit 0 of byte 0 is 1, and status bit 6 is then set. A group frame is kept only if `rx_ctrl[1]` (promiscuous) or `rx_ctrl[3]` (all groups) is set. A unicast frame is kept only if its destination equals `own_addr` or `rx_ctrl[1]` is set.
- R8: A frame with L < MIN_FRAME is a runt. Status bit 5 marks it, and it is rejected unless `rx_ctrl[2]` is set.
- R9: A frame with `rx_crc_ok` low at its last byte sets status bit 1. It is rejected when `rx_ctrl[4]` is set.
- R10: A frame with L > MAX_FRAME sets status bit 7. It is rejected when `rx_ctrl[5]` is set.
- R11: `rx_len_err` high at the last byte sets status bit 2 and does not by itself reject the frame. All other status bits are 0.
- R12: Let F = (rd_ptr - P - 1) mod RING_BYTES. Byte k of a frame is written only if k+5 <= F. Once a byte fails this test, writing stops for the rest of the frame, the frame is rejected and `irq_stat[1]` is set.
- R13: A 1 on `irq_clr[i]` clears `irq_stat[i]`. A set event in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_ctrl | input | 6 | Receive control: 0 enable, 1 promiscuous, 2 keep runts, 3 all groups, 4 drop CRC errors, 5 drop oversize |
| own_addr | input | 48 | Station address; bits 7:0 are the first destination byte |
| rx_valid | input | 1 | Received byte valid |
| rx_data | input | 8 | Received byte |
| rx_last | input | 1 | Marks the last byte of the frame |
| rx_crc_ok | input | 1 | CRC good, valid with the last byte |
| rx_len_err | input | 1 | Length error, valid with the last byte |
| rd_ptr | input | AW | Host read position in the ring |
| irq_clr | input | 2 | Write-one-to-clear for `irq_stat` |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| wr_ptr | output | AW | Committed write pointer |
| irq_stat | output | 2 | Bit 0 frame committed, bit 1 frame dropped for lack of space |

## Verification
The assertions rely on two things about the inputs. The MAC leaves at least five idle cycles after each last byte, so a new frame never starts while the header is still being written. The host never moves `rd_ptr` past `wr_ptr`, so the free-space figure never shrinks during a frame. The bench keeps seven idle cycles between frames. It moves `rd_ptr` only between frames, either up to the committed pointer or, for the space test, to a point that still lies inside the unread region. The random frames keep their length below the ring size.

// File: rtl/rxfw_pkg.sv
package rxfw_pkg;

    localparam logic [7:0] MARKER = 8'h01;

    // receive control bit positions
    localparam int CB_EN        = 0;
    localparam int CB_PROMISC   = 1;
    localparam int CB_RUNT      = 2;
    localparam int CB_ALLGRP    = 3;
    localparam int CB_DROP_CRC  = 4;
    localparam int CB_DROP_LONG = 5;

    // status byte bit positions
    localparam int SB_CRC   = 1;
    localparam int SB_LEN   = 2;
    localparam int SB_RUNT  = 5;
    localparam int SB_GROUP = 6;
    localparam int SB_LONG  = 7;

    typedef struct packed {
        logic [15:0] len;
        logic        crc_ok;
        logic        len_err;
        logic        group;
        logic        match;
        logic        ovf;
    } frame_info_t;

    typedef struct packed {
        logic       keep;
        logic [7:0] status;
    } verdict_t;

    typedef enum logic {CM_IDLE, CM_HDR} cm_state_e;

    // a + b inside a ring of n bytes; a < n and b < n
    function automatic int unsigned ring_add(int unsigned a, int unsigned b, int unsigned n);
        int unsigned s;
        s = a + b;
        if (s >= n) s = s - n;
        return s;
    endfunction

    // bytes that may be written before reaching the reader (one slot kept empty)
    function automatic int unsigned ring_free(int unsigned rd, int unsigned wr, int unsigned n);
        if (rd > wr) return rd - wr - 1;
        return rd + n - wr - 1;
    endfunction

endpackage

// File: rtl/rxfw_capture.sv
module rxfw_capture
    import rxfw_pkg::*;
#(
    parameter int RING_BYTES = 13312,
    parameter int AW         = 14
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_enable,
    input  logic [47:0]   own_addr,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          rx_last,
    input  logic          rx_crc_ok,
    input  logic          rx_len_err,
    input  logic [AW-1:0] wr_ptr,
    input  logic [AW-1:0] rd_ptr,
    output logic          cap_start,
    output logic          cap_we,
    output logic [AW-1:0] cap_addr,
    output logic [7:0]    cap_data,
    output logic          eof_q,
    output frame_info_t   info_q,
    output logic [AW-1:0] end_q
);

    logic          in_frame_q, skip_q, ovf_q;
    logic [15:0]   cnt_q;
    logic [AW-1:0] daddr_q;
    logic [47:0]   dest_q;

    logic          first, skip_now, ovf_now, fits;
    logic [15:0]   idx, len_now;
    logic [AW-1:0] addr_now, addr_inc;
    logic [47:0]   dest_now;
    logic [31:0]   room;

    always_comb begin
        first    = rx_valid && !in_frame_q;
        idx      = first ? 16'd0 : cnt_q;
        addr_now = first ? AW'(ring_add(32'(wr_ptr), 32'd4, RING_BYTES)) : daddr_q;
        addr_inc = AW'(ring_add(32'(addr_now), 32'd1, RING_BYTES));
        room     = ring_free(32'(rd_ptr), 32'(wr_ptr), RING_BYTES);
        fits     = (32'(idx) + 32'd5) <= room;
        skip_now = first ? !rx_enable : skip_q;
        ovf_now  = (!first && ovf_q) || !fits;
        len_now  = (idx == 16'hFFFF) ? idx : idx + 16'd1;
        dest_now = first ? 48'd0 : dest_q;
        if (idx < 16'd6) dest_now[idx[2:0]*8 +: 8] = rx_data;
        cap_start = first;
        cap_we    = rx_valid && !skip_now && !ovf_now;
        cap_addr  = addr_now;
        cap_data  = rx_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame_q <= 1'b0;
            skip_q     <= 1'b0;
            ovf_q      <= 1'b0;
            cnt_q      <= '0;
            daddr_q    <= '0;
            dest_q     <= '0;
            eof_q      <= 1'b0;
            info_q     <= '0;
            end_q      <= '0;
        end else begin
            eof_q <= 1'b0;
            if (rx_valid) begin
                in_frame_q <= !rx_last;
                skip_q     <= skip_now;
                ovf_q      <= ovf_now;
                cnt_q      <= len_now;
                daddr_q    <= addr_inc;
                dest_q     <= dest_now;
                if (rx_last && !skip_now) begin
                    eof_q          <= 1'b1;
                    info_q.len     <= len_now;
                    info_q.crc_ok  <= rx_crc_ok;
                    info_q.len_err <= rx_len_err;
                    info_q.group   <= dest_now[0];
                    info_q.match   <= (dest_now == own_addr);
                    info_q.ovf     <= ovf_now;
                    end_q          <= addr_inc;
                end
            end
        end
    end

    AST_DATA_BEHIND_READER: assert property (@(posedge clk) disable iff (rst)
        cap_we |-> (cap_addr != rd_ptr)) else $error("data write reached reader"); // R12

endmodule

// File: rtl/rxfw_filter.sv
module rxfw_filter
    import rxfw_pkg::*;
#(
    parameter int MIN_FRAME = 64,
    parameter int MAX_FRAME = 1522
) (
    input  logic [5:1]  rx_opts,
    input  frame_info_t info,
    output verdict_t    verdict
);

    logic runt, too_long, addr_ok;

    always_comb begin
        runt     = info.len < 16'(MIN_FRAME);
        too_long = info.len > 16'(MAX_FRAME);
        addr_ok  = rx_opts[CB_PROMISC] || (info.group ? rx_opts[CB_ALLGRP] : info.match);

        verdict.keep = !info.ovf && addr_ok
                     && (!runt || rx_opts[CB_RUNT])
                     && !(too_long && rx_opts[CB_DROP_LONG])
                     && !(!info.crc_ok && rx_opts[CB_DROP_CRC]);

        verdict.status           = 8'h00;
        verdict.status[SB_CRC]   = !info.crc_ok;
        verdict.status[SB_LEN]   = info.len_err;
        verdict.status[SB_RUNT]  = runt;
        verdict.status[SB_GROUP] = info.group;
        verdict.status[SB_LONG]  = too_long;
    end

endmodule

// File: rtl/rxfw_commit.sv
module rxfw_commit
    import rxfw_pkg::*;
#(
    parameter int RING_BYTES = 13312,
    parameter int AW         = 14
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          eof,
    input  verdict_t      verdict,
    input  logic [15:0]   len,
    input  logic          ovf,
    input  logic [AW-1:0] end_addr,
    input  logic          cap_start,
    input  logic [1:0]    irq_clr,
    output logic          cmt_we,
    output logic [AW-1:0] cmt_addr,
    output logic [7:0]    cmt_data,
    output logic [AW-1:0] wr_ptr,
    output logic [1:0]    irq_stat
);

    cm_state_e     st_q;
    logic [1:0]    hidx_q;
    logic [15:0]   len_q;
    logic [7:0]    stat_q;
    logic [AW-1:0] end_addr_q;
    logic [1:0]    irq_set;

    always_comb begin
        cmt_we   = (st_q == CM_HDR);
        cmt_addr = AW'(ring_add(32'(wr_ptr), 32'(hidx_q), RING_BYTES));
        case (hidx_q)
            2'd3:    cmt_data = len_q[15:8];
            2'd2:    cmt_data = len_q[7:0];
            2'd1:    cmt_data = stat_q;
            default: cmt_data = MARKER;
        endcase
        irq_set[0] = (st_q == CM_HDR) && (hidx_q == 2'd0);
        irq_set[1] = eof && ovf;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= CM_IDLE;
            hidx_q     <= 2'd0;
            len_q      <= '0;
            stat_q     <= '0;
            end_addr_q <= '0;
            wr_ptr     <= '0;
            irq_stat   <= '0;
        end else begin
            irq_stat <= (irq_stat & ~irq_clr) | irq_set;
            case (st_q)
                CM_IDLE: if (eof && verdict.keep) begin
                    st_q       <= CM_HDR;
                    hidx_q     <= 2'd3;
                    len_q      <= len;
                    stat_q     <= verdict.status;
                    end_addr_q <= end_addr;
                end
                default: begin
                    if (hidx_q == 2'd0) begin
                        st_q   <= CM_IDLE;
                        wr_ptr <= end_addr_q;
                    end else begin
                        hidx_q <= hidx_q - 2'd1;
                    end
                end
            endcase
        end
    end

    AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        (st_q == CM_HDR) |-> !cap_start) else $error("frame started during header write"); // R4

endmodule

// File: rtl/rxfw_writer.sv
module rxfw_writer
    import rxfw_pkg::*;
#(
    parameter int RING_BYTES = 13312,
    parameter int MIN_FRAME  = 64,
    parameter int MAX_FRAME  = 1522,
    parameter int AW         = $clog2(RING_BYTES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [5:0]    rx_ctrl,
    input  logic [47:0]   own_addr,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic          rx_last,
    input  logic          rx_crc_ok,
    input  logic          rx_len_err,
    input  logic [AW-1:0] rd_ptr,
    input  logic [1:0]    irq_clr,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    output logic [AW-1:0] wr_ptr,
    output logic [1:0]    irq_stat
);

    logic          cap_start, cap_we, eof;
    logic [AW-1:0] cap_addr, end_addr, cmt_addr;
    logic [7:0]    cap_data, cmt_data;
    logic          cmt_we;
    frame_info_t   info;
    verdict_t      verdict;

    rxfw_capture #(.RING_BYTES(RING_BYTES), .AW(AW)) u_cap (
        .clk(clk), .rst(rst), .rx_enable(rx_ctrl[CB_EN]), .own_addr(own_addr),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .rx_crc_ok(rx_crc_ok), .rx_len_err(rx_len_err),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
        .cap_start(cap_start), .cap_we(cap_we), .cap_addr(cap_addr), .cap_data(cap_data),
        .eof_q(eof), .info_q(info), .end_q(end_addr)
    );

    rxfw_filter #(.MIN_FRAME(MIN_FRAME), .MAX_FRAME(MAX_FRAME)) u_flt (
        .rx_opts(rx_ctrl[5:1]), .info(info), .verdict(verdict)
    );

    rxfw_commit #(.RING_BYTES(RING_BYTES), .AW(AW)) u_cmt (
        .clk(clk), .rst(rst), .eof(eof), .verdict(verdict), .len(info.len), .ovf(info.ovf),
        .end_addr(end_addr), .cap_start(cap_start), .irq_clr(irq_clr),
        .cmt_we(cmt_we), .cmt_addr(cmt_addr), .cmt_data(cmt_data),
        .wr_ptr(wr_ptr), .irq_stat(irq_stat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we    <= cap_we || cmt_we;
            mem_addr  <= cmt_we ? cmt_addr : cap_addr;
            mem_wdata <= cmt_we ? cmt_data : cap_data;
        end
    end

    AST_ONE_WRITER: assert property (@(posedge clk) disable iff (rst)
        !(cap_we && cmt_we)) else $error("data and header write collide"); // R3

    AST_MARKER_LAST: assert property (@(posedge clk) disable iff (rst)
        (wr_ptr != $past(wr_ptr)) |-> (mem_we && mem_addr == $past(wr_ptr) && mem_wdata == MARKER))
        else $error("pointer moved without marker write"); // R3

    AST_DONE_WITH_PTR: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_stat[0]) |-> (wr_ptr != $past(wr_ptr))) else $error("done without commit"); // R4

    AST_OVF_KEEPS_PTR: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_stat[1]) |-> $stable(wr_ptr)) else $error("overflow moved pointer"); // R12

endmodule

// File: tb/rxfw_writer_test.sv
module rxfw_writer_test;

    localparam int N   = 256;
    localparam int AW  = 8;
    localparam int MNF = 64;
    localparam int MXF = 100;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [5:0]    rx_ctrl = 6'b000001;
    logic [47:0]   own_addr = 48'h5A4B3C2D1E02;
    logic          rx_valid = 1'b0, rx_last = 1'b0, rx_crc_ok = 1'b1, rx_len_err = 1'b0;
    logic [7:0]    rx_data = 8'h00;
    logic [AW-1:0] rd_ptr = '0;
    logic [1:0]    irq_clr = 2'b00;
    logic          mem_we;
    logic [AW-1:0] mem_addr, wr_ptr;
    logic [7:0]    mem_wdata;
    logic [1:0]    irq_stat;

    int checks = 0;
    int fails  = 0;

    logic [7:0]    mem_model [0:N-1];
    logic [7:0]    fr [0:255];
    int            wcount = 0;
    int            hits   = 0;
    logic [AW-1:0] watch_a = '0;
    logic [AW-1:0] last_a  = '0;
    logic [7:0]    last_d  = '0;
    int            exp_wr  = 0;
    logic [1:0]    exp_irq = 2'b00;

    always #2.5 clk = ~clk;   // 200 MHz

    rxfw_writer #(.RING_BYTES(N), .MIN_FRAME(MNF), .MAX_FRAME(MXF)) uut (
        .clk(clk), .rst(rst), .rx_ctrl(rx_ctrl), .own_addr(own_addr),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
        .rx_crc_ok(rx_crc_ok), .rx_len_err(rx_len_err), .rd_ptr(rd_ptr), .irq_clr(irq_clr),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .wr_ptr(wr_ptr), .irq_stat(irq_stat)
    );

    always @(posedge clk) begin
        if (mem_we) begin
            mem_model[mem_addr] <= mem_wdata;
            wcount <= wcount + 1;
            last_a <= mem_addr;
            last_d <= mem_wdata;
            if (mem_addr == watch_a) hits <= hits + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit exp_keep(logic [5:0] c, int len, int kind, bit crc, bit ovf);
        bit grp = (kind >= 2);
        bit adr = c[1] || (grp ? c[3] : (kind == 0));
        return !ovf && adr && (len >= MNF || c[2]) && !(len > MXF && c[5]) && !(!crc && c[4]);
    endfunction

    function automatic logic [7:0] exp_status(int len, int kind, bit crc, bit lerr);
        logic [7:0] s = 8'h00;
        s[1] = !crc;
        s[2] = lerr;
        s[5] = (len < MNF);
        s[6] = (kind >= 2);
        s[7] = (len > MXF);
        return s;
    endfunction

    // kind: 0 own unicast, 1 other unicast, 2 multicast, 3 broadcast
    task automatic send(input int len, input int kind, input bit crc, input bit lerr,
                        input bit clr_mid, input string tag);
        int base, room, w0, h0, bad;
        bit en, ovf, keep;
        logic [7:0] st;
        for (int i = 0; i < len; i++) fr[i] = 8'($urandom);
        for (int i = 0; i < 6 && i < len; i++) begin
            case (kind)
                0: fr[i] = own_addr[8*i +: 8];
                1: fr[i] = (i == 5) ? ~own_addr[47:40] : own_addr[8*i +: 8];
                2: fr[i] = (i == 0) ? 8'h33 : fr[i];
                default: fr[i] = 8'hFF;
            endcase
        end
        base = exp_wr;
        room = (int'(rd_ptr) > base) ? int'(rd_ptr) - base - 1 : int'(rd_ptr) + N - base - 1;
        en   = rx_ctrl[0];
        ovf  = (len + 4 > room);
        keep = en && exp_keep(rx_ctrl, len, kind, crc, ovf);
        st   = exp_status(len, kind, crc, lerr);
        watch_a = AW'(base);
        @(negedge clk);
        w0 = wcount;
        h0 = hits;
        for (int i = 0; i < len; i++) begin
            if (i > 0) @(negedge clk);
            rx_valid   = 1'b1;
            rx_data    = fr[i];
            rx_last    = (i == len - 1);
            rx_crc_ok  = crc;
            rx_len_err = lerr;
        end
        for (int j = 1; j <= 7; j++) begin
            @(negedge clk);
            if (j == 1) begin rx_valid = 1'b0; rx_last = 1'b0; end
            if (j == 5 && clr_mid) irq_clr = 2'b01;
            if (j == 6) irq_clr = 2'b00;
        end
        if (keep) begin
            exp_wr = (base + len + 4) % N;
            exp_irq[0] = 1'b1;
        end
        if (en && ovf) exp_irq[1] = 1'b1;
        chk(wr_ptr == AW'(exp_wr), "R4", {tag, " wr_ptr"}, int'(wr_ptr), exp_wr);
        chk(irq_stat == exp_irq, "R4", {tag, " irq_stat"}, int'(irq_stat), int'(exp_irq));
        if (keep) begin
            bad = 0;
            if (mem_model[base] != 8'h01) bad++;
            if (mem_model[(base + 1) % N] != st) bad++;
            if (mem_model[(base + 2) % N] != 8'(len)) bad++;
            if (mem_model[(base + 3) % N] != 8'(len >> 8)) bad++;
            for (int i = 0; i < len; i++)
                if (mem_model[(base + 4 + i) % N] != fr[i]) bad++;
            chk(bad == 0, "R2", {tag, " stored bytes mismatching"}, bad, 0);
            chk(last_a == AW'(base) && last_d == 8'h01, "R3", {tag, " final write addr"},
                int'(last_a), base);
        end else if (en) begin
            chk(hits == h0, "R5", {tag, " header writes on drop"}, hits - h0, 0);
        end else begin
            chk(wcount == w0, "R6", {tag, " writes while disabled"}, wcount - w0, 0);
        end
        if (en && ovf)
            chk(wcount - w0 == ((room >= 5) ? room - 4 : 0), "R12", {tag, " writes before stop"},
                wcount - w0, room - 4);
    endtask

    task automatic host_drain();
        @(negedge clk);
        irq_clr = 2'b11;
        rd_ptr  = AW'(exp_wr);
        @(negedge clk);
        irq_clr = 2'b00;
        exp_irq = 2'b00;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(wr_ptr == '0, "R1", "reset wr_ptr", int'(wr_ptr), 0);
        chk(irq_stat == 2'b00, "R1", "reset irq_stat", int'(irq_stat), 0);
        chk(mem_we == 1'b0, "R1", "reset mem_we", int'(mem_we), 0);

        rx_ctrl = 6'b000001;
        send(70, 0, 1, 0, 0, "R2 own unicast");   host_drain();
        send(70, 1, 1, 0, 0, "R7 foreign unicast"); host_drain();
        rx_ctrl = 6'b000011;
        send(72, 1, 1, 0, 0, "R7 promiscuous");   host_drain();
        rx_ctrl = 6'b000001;
        send(80, 2, 1, 0, 0, "R7 group no accept"); host_drain();
        rx_ctrl = 6'b001001;
        send(80, 2, 1, 0, 0, "R7 group accepted"); host_drain();
        send(66, 3, 1, 0, 0, "R7 broadcast");     host_drain();
        rx_ctrl = 6'b000001;
        send(40, 0, 1, 0, 0, "R8 runt dropped");  host_drain();
        rx_ctrl = 6'b000101;
        send(40, 0, 1, 0, 0, "R8 runt kept");     host_drain();
        rx_ctrl = 6'b010001;
        send(70, 0, 0, 0, 0, "R9 crc dropped");   host_drain();
        rx_ctrl = 6'b000001;
        send(70, 0, 0, 0, 0, "R9 crc kept");      host_drain();
        rx_ctrl = 6'b100001;
        send(120, 0, 1, 0, 0, "R10 long dropped"); host_drain();
        rx_ctrl = 6'b000001;
        send(120, 0, 1, 0, 0, "R10 long kept");   host_drain();
        send(68, 0, 1, 1, 0, "R11 length flag");  host_drain();
        rx_ctrl = 6'b000000;
        send(70, 0, 1, 0, 0, "R6 disabled");      host_drain();
        rx_ctrl = 6'b000001;

        // R13: clear of bit 0 in the commit cycle loses to the set
        send(70, 0, 1, 0, 1, "R13 set beats clear");
        // R12: reader only 20 bytes ahead
        rd_ptr = AW'((exp_wr + 20) % N);
        send(40, 0, 1, 0, 0, "R12 no room");
        chk(irq_stat == 2'b11, "R13", "both bits pending", int'(irq_stat), 3);
        @(negedge clk); irq_clr = 2'b01;
        @(negedge clk); irq_clr = 2'b00;
        chk(irq_stat == 2'b10, "R13", "clear bit0 only", int'(irq_stat), 2);
        exp_irq = 2'b10;
        host_drain();

        for (int n = 0; n < 150; n++) begin
            logic [5:0] c;
            c = 6'($urandom);
            if ($urandom % 8 != 0) c[0] = 1'b1;
            rx_ctrl = c;
            send(1 + int'($urandom % 130), int'($urandom % 4), ($urandom % 4) != 0,
                 ($urandom % 8) == 0, 0, "R2 random");
            host_drain();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule